// File: doc/BRIEF.md
# Flash Command Decoder

This block models the command interface of a small byte-wide flash array whose only erase is a whole-array erase. A host drives bus cycles with active-low chip enable, write enable and output enable, plus an address and a data byte. Write cycles carry command bytes into a command register. Read cycles return array bytes, identifier codes or the byte under verification, depending on the mode the last command selected.

Erase and program are two-cycle operations. The second write of each starts an internal operation. The operation runs until one of three things ends it: a verify command, whose own write stops it and commits the result; a stop timer, which commits it after a fixed number of clock cycles; or a double reset command, which discards it. Each byte of the array is a register. An erase sets every byte to FFh. A program operation ANDs the latched data into one byte, so it can only clear bits. A high-voltage enable input stands for the programming supply: while it is low, the block only reads the array.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: At reset, and in every cycle that hv_en_i is low, the block returns to array-read mode, ignores writes and drops any running operation without changing the array. Every array byte resets to FFh.
- R2: Writing 00h selects array-read mode. Each read then returns the array byte at addr_i.
- R3: Writing 90h selects identifier mode. A read at address 0 returns 20h, a read at address 1 returns 07h and a read at any other address returns 00h.
- R4: A write of 20h followed directly by a second write of 20h starts an erase and raises busy_o. When the erase ends by verify or by the timer, every byte reads FFh.
- R5: A write of 40h arms program. The next write supplies address and data and starts programming, which raises busy_o. When it commits, the byte holds its old value AND the data.
- R6: A write of A0h stops a running erase and commits it. It also latches the address given with that write. The following reads return the byte at that latched address, whatever addr_i is.
- R7: A write of C0h stops a running program and commits it. The following reads return the byte at the address latched by the program data write.
- R8: An erase not stopped by a verify keeps busy_o high for exactly ERASE_LIMIT clock cycles. A program keeps it high for exactly PGM_LIMIT cycles. Each then commits its result and waits idle.
- R9: Two consecutive writes of FFh abort a running erase or program without changing the array and return to array-read mode.
- R10: Any command byte other than 00h, 90h, 20h, 40h, A0h, C0h or FFh returns the block to array-read mode.
- R11: A write needs ce_ni and we_ni both low. The address is taken in the first cycle of the write and the data in the cycle that ends it. A we_ni pulse while ce_ni is high has no effect.
- R12: rd_valid_o is high only while ce_ni and oe_ni are low and we_ni is high. At all other times rdata_o is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hv_en_i | input | 1 | Programming supply present; low forces read-only behaviour |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data / command byte |
| rdata_o | output | 8 | Read data, 00h when no read is active |
| rd_valid_o | output | 1 | A read cycle is active |
| busy_o | output | 1 | An erase or program operation is running |

## Verification
The assertions assume that the bus strobes are synchronous to clk_i. They also assume that a write holds ce_ni and we_ni low for at least one sampled cycle, and that data_i is still valid in the cycle where the strobe rises. The bench changes inputs only on falling clock edges. Every write holds both strobes low for at least one full cycle and keeps data until after we_ni is high again. The bench never asserts we_ni and oe_ni together, so a read can never be mistaken for a write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    M_READ, M_SIG, M_ERS_SET, M_ERS_VFY, M_PGM_SET, M_PGM_VFY, M_RST_SET, M_OP
  } mode_e;

  typedef enum logic [1:0] {OP_NONE, OP_ERASE, OP_PROG} op_e;

  localparam logic [7:0] CMD_READ = 8'h00;
  localparam logic [7:0] CMD_SIG  = 8'h90;
  localparam logic [7:0] CMD_ERS  = 8'h20;
  localparam logic [7:0] CMD_EVFY = 8'hA0;
  localparam logic [7:0] CMD_PGM  = 8'h40;
  localparam logic [7:0] CMD_PVFY = 8'hC0;
  localparam logic [7:0] CMD_RST  = 8'hFF;
  localparam logic [7:0] ID_MFR   = 8'h20;
  localparam logic [7:0] ID_DEV   = 8'h07;
endpackage

// File: rtl/flash_bus_sampler.sv
module flash_bus_sampler #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              wr_end_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              rd_act_o
);
  logic              wr_act, wr_q;
  logic [ADDR_W-1:0] addr_q;

  assign wr_act = !ce_ni && !we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      wr_q <= wr_act;
      if (wr_act && !wr_q) addr_q <= addr_i;  // strobe falling edge
    end
  end

  assign wr_end_o  = wr_q && !wr_act;         // strobe rising edge
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_i;
  assign rd_act_o  = !ce_ni && !oe_ni && we_ni;

  assert_addr_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q && wr_act) |=> (addr_q == $past(addr_q)));
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic              pgm_i,
  input  logic [ADDR_W-1:0] pgm_addr_i,
  input  logic [7:0]        pgm_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (pgm_i) begin
      mem[pgm_addr_i] <= mem[pgm_addr_i] & pgm_data_i;
    end
  end

  assign rd_data_o = mem[rd_addr_i];

  assert_pgm_clears_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgm_i && !erase_i) |=> ((mem[$past(pgm_addr_i)] & ~$past(pgm_data_i)) == 8'h00));
  assert_erase_all_ones_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (mem[$past(rd_addr_i)] == 8'hFF));
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int ERASE_LIMIT = 64,
  parameter int PGM_LIMIT   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hv_en_i,
  input  logic              wr_end_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output mode_e             mode_o,
  output logic              busy_o,
  output logic              commit_ers_o,
  output logic              commit_pgm_o,
  output logic [ADDR_W-1:0] pgm_addr_o,
  output logic [7:0]        pgm_data_o,
  output logic [ADDR_W-1:0] vfy_addr_o
);
  localparam int MAX_LIM = (ERASE_LIMIT > PGM_LIMIT) ? ERASE_LIMIT : PGM_LIMIT;
  localparam int TMR_W   = $clog2(MAX_LIM + 1);
  localparam logic [TMR_W-1:0] ERS_LAST = TMR_W'(ERASE_LIMIT - 1);
  localparam logic [TMR_W-1:0] PGM_LAST = TMR_W'(PGM_LIMIT - 1);

  mode_e             mode_q, mode_d;
  op_e               op_q, op_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [ADDR_W-1:0] pa_q, pa_d, ea_q, ea_d;
  logic [7:0]        pd_q, pd_d;
  logic              lim_hit, c_ers, c_pgm;

  always_comb begin
    mode_d = mode_q;
    op_d   = op_q;
    tmr_d  = tmr_q;
    pa_d   = pa_q;
    pd_d   = pd_q;
    ea_d   = ea_q;
    c_ers  = 1'b0;
    c_pgm  = 1'b0;
    lim_hit = (op_q == OP_ERASE && tmr_q == ERS_LAST) ||
              (op_q == OP_PROG  && tmr_q == PGM_LAST);

    if (op_q != OP_NONE) begin
      if (lim_hit) begin
        op_d  = OP_NONE;
        c_ers = (op_q == OP_ERASE);
        c_pgm = (op_q == OP_PROG);
      end else begin
        tmr_d = tmr_q + 1'b1;
      end
    end

    if (wr_end_i) begin
      if (mode_q == M_PGM_SET) begin
        pa_d   = wr_addr_i;
        pd_d   = wr_data_i;
        op_d   = OP_PROG;
        tmr_d  = '0;
        mode_d = M_OP;
      end else if (mode_q == M_ERS_SET && wr_data_i == CMD_ERS) begin
        op_d   = OP_ERASE;
        tmr_d  = '0;
        mode_d = M_OP;
      end else if (mode_q == M_RST_SET && wr_data_i == CMD_RST) begin
        op_d   = OP_NONE;
        mode_d = M_READ;
        c_ers  = 1'b0;
        c_pgm  = 1'b0;
      end else begin
        unique case (wr_data_i)
          CMD_READ: mode_d = M_READ;
          CMD_SIG:  mode_d = M_SIG;
          CMD_ERS:  mode_d = M_ERS_SET;
          CMD_PGM:  mode_d = M_PGM_SET;
          CMD_RST:  mode_d = M_RST_SET;
          CMD_EVFY: begin
            mode_d = M_ERS_VFY;
            ea_d   = wr_addr_i;
            if (op_q == OP_ERASE) begin
              op_d  = OP_NONE;
              c_ers = 1'b1;
            end
          end
          CMD_PVFY: begin
            mode_d = M_PGM_VFY;
            if (op_q == OP_PROG) begin
              op_d  = OP_NONE;
              c_pgm = 1'b1;
            end
          end
          default:  mode_d = M_READ;
        endcase
      end
    end

    if (!hv_en_i) begin
      mode_d = M_READ;
      op_d   = OP_NONE;
      c_ers  = 1'b0;
      c_pgm  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_READ;
      op_q   <= OP_NONE;
      tmr_q  <= '0;
      pa_q   <= '0;
      pd_q   <= 8'hFF;
      ea_q   <= '0;
    end else begin
      mode_q <= mode_d;
      op_q   <= op_d;
      tmr_q  <= tmr_d;
      pa_q   <= pa_d;
      pd_q   <= pd_d;
      ea_q   <= ea_d;
    end
  end

  assign mode_o       = mode_q;
  assign busy_o       = (op_q != OP_NONE);
  assign commit_ers_o = c_ers;
  assign commit_pgm_o = c_pgm;
  assign pgm_addr_o   = pa_q;
  assign pgm_data_o   = pd_q;
  assign vfy_addr_o   = ea_q;

  assert_hv_low_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hv_en_i |=> (mode_q == M_READ && op_q == OP_NONE));
  assert_erase_timer_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_ERASE) |-> (tmr_q < TMR_W'(ERASE_LIMIT)));
  assert_pgm_timer_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_PROG) |-> (tmr_q < TMR_W'(PGM_LIMIT)));
  assert_evfy_stops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_end_i && mode_q != M_PGM_SET && wr_data_i == CMD_EVFY) |=> (op_q != OP_ERASE));
  assert_pvfy_stops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_end_i && mode_q != M_PGM_SET && wr_data_i == CMD_PVFY) |=> (op_q != OP_PROG));
  assert_reset_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_end_i && mode_q == M_RST_SET && wr_data_i == CMD_RST)
      |-> (!commit_ers_o && !commit_pgm_o));
  assert_one_commit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({commit_ers_o, commit_pgm_o}));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int ERASE_LIMIT = 64,
  parameter int PGM_LIMIT   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hv_en_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        rdata_o,
  output logic              rd_valid_o,
  output logic              busy_o
);
  logic              wr_end, rd_act, c_ers, c_pgm;
  logic [ADDR_W-1:0] wr_addr, pgm_addr, vfy_addr, arr_addr;
  logic [7:0]        wr_data, pgm_data, arr_data, sig_data;
  mode_e             mode;

  flash_bus_sampler #(.ADDR_W(ADDR_W)) u_bus (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .addr_i, .data_i,
    .wr_end_o(wr_end), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rd_act_o(rd_act)
  );

  flash_cmd_fsm #(.ADDR_W(ADDR_W), .ERASE_LIMIT(ERASE_LIMIT), .PGM_LIMIT(PGM_LIMIT)) u_fsm (
    .clk_i, .rst_ni, .hv_en_i,
    .wr_end_i(wr_end), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .mode_o(mode), .busy_o(busy_o), .commit_ers_o(c_ers), .commit_pgm_o(c_pgm),
    .pgm_addr_o(pgm_addr), .pgm_data_o(pgm_data), .vfy_addr_o(vfy_addr)
  );

  always_comb begin
    unique case (mode)
      M_ERS_VFY: arr_addr = vfy_addr;
      M_PGM_VFY: arr_addr = pgm_addr;
      default:   arr_addr = addr_i;
    endcase
  end

  flash_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk_i, .rst_ni, .erase_i(c_ers), .pgm_i(c_pgm),
    .pgm_addr_i(pgm_addr), .pgm_data_i(pgm_data),
    .rd_addr_i(arr_addr), .rd_data_o(arr_data)
  );

  always_comb begin
    if (addr_i == ADDR_W'(0))      sig_data = ID_MFR;
    else if (addr_i == ADDR_W'(1)) sig_data = ID_DEV;
    else                           sig_data = 8'h00;
  end

  assign rd_valid_o = rd_act;
  assign rdata_o    = !rd_act ? 8'h00 : (mode == M_SIG) ? sig_data : arr_data;

  assert_sig_codes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && mode == M_SIG && addr_i > ADDR_W'(1)) |-> (rdata_o == 8'h00));
  assert_no_busy_hv_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hv_en_i |=> !busy_o);
endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb_top;
  localparam int AW = 4;
  localparam int ELIM = 64;
  localparam int PLIM = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hv_en = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = 8'h00;
  logic [7:0] rdata;
  logic rd_valid, busy;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .ERASE_LIMIT(ELIM), .PGM_LIMIT(PLIM)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hv_en_i(hv_en), .ce_ni(ce_n), .we_ni(we_n),
    .oe_ni(oe_n), .addr_i(addr), .data_i(data),
    .rdata_o(rdata), .rd_valid_o(rd_valid), .busy_o(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; data = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic bus_write_split(input logic [AW-1:0] a1, input logic [AW-1:0] a2,
                                 input logic [7:0] d);
    @(negedge clk); addr = a1; data = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); addr = a2;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #1 d = rdata;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 busy after reset", busy, 0);
    chk("R12 idle valid", rd_valid, 0);
    chk("R12 idle data", rdata, 8'h00);
    bus_read(4'd3, d);
    chk("R1 reset content", d, 8'hFF);
  endtask

  task automatic t_signature();
    logic [7:0] d;
    bus_write(4'd0, 8'h90);
    bus_read(4'd0, d); chk("R3 manufacturer id", d, 8'h20);
    bus_read(4'd1, d); chk("R3 device id", d, 8'h07);
    bus_read(4'd5, d); chk("R3 other address", d, 8'h00);
  endtask

  task automatic t_program_verify();
    logic [7:0] d;
    bus_write(4'd0, 8'h40);
    bus_write(4'd3, 8'h5A);
    chk("R5 busy during program", busy, 1);
    bus_write(4'd0, 8'hC0);
    chk("R7 program stopped", busy, 0);
    bus_read(4'd9, d); chk("R7 verify reads program addr", d, 8'h5A);
    bus_write(4'd0, 8'h40);
    bus_write(4'd3, 8'h0F);
    bus_write(4'd0, 8'hC0);
    bus_read(4'd0, d); chk("R5 AND into byte", d, 8'h0A);
  endtask

  task automatic t_read_mode();
    logic [7:0] d;
    bus_write(4'd0, 8'h00);
    bus_read(4'd3, d); chk("R2 read addr 3", d, 8'h0A);
    bus_read(4'd4, d); chk("R2 read addr 4", d, 8'hFF);
  endtask

  task automatic t_reset_abort();
    logic [7:0] d;
    bus_write(4'd0, 8'h40);
    bus_write(4'd4, 8'h00);
    chk("R9 busy before abort", busy, 1);
    bus_write(4'd0, 8'hFF);
    bus_write(4'd0, 8'hFF);
    chk("R9 busy after abort", busy, 0);
    bus_read(4'd4, d); chk("R9 array untouched", d, 8'hFF);
  endtask

  task automatic t_program_timeout();
    logic [7:0] d;
    int n;
    bus_write(4'd0, 8'h40);
    bus_write(4'd5, 8'h33);
    count_busy(n);
    chk("R8 program busy cycles", n, PLIM);
    bus_read(4'd5, d); chk("R8 program committed by timer", d, 8'h33);
  endtask

  task automatic t_addr_capture();
    logic [7:0] d;
    bus_write(4'd0, 8'h40);
    bus_write_split(4'd6, 4'd7, 8'h3C);
    bus_write(4'd0, 8'hC0);
    bus_read(4'd7, d); chk("R11 first-cycle address used", d, 8'h3C);
    bus_write(4'd0, 8'h00);
    bus_read(4'd7, d); chk("R11 later address untouched", d, 8'hFF);
  endtask

  task automatic t_erase_verify();
    logic [7:0] d;
    bus_write(4'd0, 8'h20);
    bus_write(4'd0, 8'h20);
    chk("R4 busy during erase", busy, 1);
    bus_write(4'd3, 8'hA0);
    chk("R6 erase stopped", busy, 0);
    bus_read(4'd0, d); chk("R6 verify reads latched addr", d, 8'hFF);
    bus_write(4'd5, 8'hA0);
    bus_read(4'd1, d); chk("R4 addr 5 erased", d, 8'hFF);
  endtask

  task automatic t_erase_timeout();
    logic [7:0] d;
    int n;
    bus_write(4'd0, 8'h40);
    bus_write(4'd2, 8'h00);
    bus_write(4'd0, 8'hC0);
    bus_read(4'd0, d); chk("R7 program addr 2", d, 8'h00);
    bus_write(4'd0, 8'h20);
    bus_write(4'd0, 8'h20);
    count_busy(n);
    chk("R8 erase busy cycles", n, ELIM);
    bus_write(4'd0, 8'h00);
    bus_read(4'd2, d); chk("R8 erase committed by timer", d, 8'hFF);
  endtask

  task automatic t_unknown();
    logic [7:0] d;
    bus_write(4'd0, 8'h90);
    bus_write(4'd0, 8'h55);
    bus_read(4'd0, d); chk("R10 unknown byte gives array read", d, 8'hFF);
  endtask

  task automatic t_hv_low();
    logic [7:0] d;
    bus_write(4'd0, 8'h90);
    @(negedge clk); hv_en = 1'b0;
    @(negedge clk);
    bus_read(4'd0, d); chk("R1 hv low forces array read", d, 8'hFF);
    bus_write(4'd0, 8'h90);
    bus_read(4'd0, d); chk("R1 write ignored when hv low", d, 8'hFF);
    @(negedge clk); hv_en = 1'b1;
    bus_write(4'd0, 8'h40);
    bus_write(4'd8, 8'h00);
    chk("R1 program running", busy, 1);
    @(negedge clk); hv_en = 1'b0;
    @(negedge clk);
    chk("R1 hv low stops program", busy, 0);
    hv_en = 1'b1;
    bus_write(4'd0, 8'h00);
    bus_read(4'd8, d); chk("R1 aborted program left byte", d, 8'hFF);
  endtask

  task automatic t_strobe_rules();
    logic [7:0] d;
    bus_write(4'd0, 8'h00);
    @(negedge clk); addr = 4'd0; data = 8'h90; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
    bus_read(4'd0, d); chk("R11 write without chip enable ignored", d, 8'hFF);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
    #1 chk("R12 oe high no valid", rd_valid, 0);
    chk("R12 oe high data zero", rdata, 8'h00);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
    #1 chk("R12 ce high no valid", rd_valid, 0);
    chk("R12 ce high data zero", rdata, 8'h00);
    @(negedge clk); oe_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_signature();
    t_program_verify();
    t_read_mode();
    t_reset_abort();
    t_program_timeout();
    t_addr_capture();
    t_erase_verify();
    t_erase_timeout();
    t_unknown();
    t_hv_low();
    t_strobe_rules();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule